// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a target FPGA through its passive serial configuration pins. After a start request it pulls the active-low program line down to clear the target. It waits for the target to pull its init line low, then releases program and waits for init to go high again. It then takes configuration bits one at a time from an upstream source over a valid/ready handshake. Each bit goes out on the data and configuration-clock pins in a fixed four-phase pattern. After a bit marked as last, the block waits for the target's done line and posts a result code.

Each of the three handshake waits has its own timeout window. A window is counted in ticks, and one tick is a parameterised number of system clock cycles. The window reloads when its wait phase begins. A timeout ends the run with a code that names the phase that failed. The init and done inputs pass through a synchroniser before the state machine reads them. Parsing and decompressing the bitstream are left to the upstream source.

Top module: `cfg_loader`

## Requirements
- R1: After reset, and whenever busy_o is low, prog_n_o, cclk_o and cdata_o are all high. After reset, busy_o, finish_o and bit_ready_o are low and result_o is 3'b000.
- R2: When start_i is high while the block is idle, the next cycle shows prog_n_o low, cclk_o and cdata_o high, and busy_o high.
- R3: When the synchronised init input is seen low during the first wait, prog_n_o returns high. If init stays high for WIN_INIT_LO*TICK_DIV cycles, the run ends with result_o = 3'b111 (-1 in 3-bit two's complement). The end comes between WIN_INIT_LO*TICK_DIV and WIN_INIT_LO*TICK_DIV+3 cycles after start is taken.
- R4: After prog_n_o is released, the block waits for init to go high. If init stays low for WIN_INIT_HI ticks, the run ends with result_o = 3'b110 (-2).
- R5: Bits are accepted only after init has gone high. bit_ready_o is high only while the block waits for a bit, and a bit is taken on a clock edge where both bit_valid_i and bit_ready_o are high. Every offered bit is shifted out exactly once, in order.
- R6: Each bit produces four phases of PHASE_CYC cycles each, in this order: (cclk low, cdata high), (cclk low, cdata = bit), (cclk high, cdata = bit), (cclk high, cdata high). cclk therefore stays low for 2*PHASE_CYC cycles per bit.
- R7: prog_n_o stays high while bits are being requested or shifted.
- R8: After the bit flagged by bit_last_i has finished, the block waits for done. A synchronised done high ends the run with result_o = 3'b000. If done stays low for WIN_DONE ticks, the run ends with 3'b101 (-3). result_o only ever holds one of these four codes.
- R9: At the end of a run, finish_o is high for exactly one cycle. busy_o falls in that same cycle, and result_o keeps its value until the next run ends.
- R10: Each wait phase reloads its own timeout window on entry. A run where every response arrives just inside its own window therefore succeeds, even when the total wait is longer than any single window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a configuration run (taken while idle) |
| bit_valid_i | input | 1 | Upstream offers a configuration bit |
| bit_data_i | input | 1 | Offered bit value |
| bit_last_i | input | 1 | Offered bit is the final one |
| bit_ready_o | output | 1 | Block is waiting for the next bit |
| prog_n_o | output | 1 | Active-low program line to target |
| cclk_o | output | 1 | Configuration clock to target |
| cdata_o | output | 1 | Configuration data to target |
| init_i | input | 1 | Target init line (asynchronous) |
| done_i | input | 1 | Target done line (asynchronous) |
| busy_o | output | 1 | Run in progress |
| finish_o | output | 1 | One-cycle end-of-run pulse |
| result_o | output | 3 | Result code: 000 ok, 111 init-low timeout, 110 init-high timeout, 101 done timeout |

## Verification
The assertions check several pin rules on every cycle. The pins are high while idle. Program is held high whenever the clock is low or a bit is requested. Data is stable across each rising clock and high around each falling clock. The finish pulse is one cycle long, busy falls only together with it, the result moves only with it, and the code is always legal. Some behaviour only the bench scenarios can show: which code each failing phase produces, how long the init-low timeout takes, that the bit order matches the upstream stream under random valid gaps, that each phase lasts the right number of cycles, and that every window reloads when its phase begins.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_LO,
    ST_WAIT_HI,
    ST_FETCH,
    ST_SHIFT,
    ST_WAIT_DONE
  } cfgl_state_e;

  localparam logic [2:0] RES_OK      = 3'b000;
  localparam logic [2:0] RES_INIT_LO = 3'b111;
  localparam logic [2:0] RES_INIT_HI = 3'b110;
  localparam logic [2:0] RES_DONE    = 3'b101;

  // {clock, data} for phase index 0..3 of one bit
  function automatic logic [1:0] phase_pins(input logic [1:0] ph, input logic b);
    case (ph)
      2'd0:    phase_pins = {1'b0, 1'b1};
      2'd1:    phase_pins = {1'b0, b};
      2'd2:    phase_pins = {1'b1, b};
      default: phase_pins = {1'b1, 1'b1};
    endcase
  endfunction

endpackage

// File: rtl/cfgl_sync.sv
module cfgl_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[g]}};
      else     chain <= {chain[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/cfgl_timer.sv
module cfgl_timer #(
  parameter int TICK_DIV = 4,
  parameter int CW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] limit_i,
  output logic          expired_o
);

  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_TOP = PW'(TICK_DIV - 1);

  logic [PW-1:0] pre_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      pre_q <= '0;
      cnt_q <= limit_i;
    end else if (cnt_q != '0) begin
      if (pre_q == PRE_TOP) begin
        pre_q <= '0;
        cnt_q <= cnt_q - 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/cfgl_bitphase.sv
module cfgl_bitphase
  import cfgl_pkg::*;
#(
  parameter int PHASE_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  input  logic bit_i,
  output logic cclk_o,
  output logic cdata_o,
  output logic fin_o
);

  localparam int DW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [DW-1:0] DWELL_TOP = DW'(PHASE_CYC - 1);

  logic          active_q;
  logic [1:0]    ph_q;
  logic [DW-1:0] dwell_q;
  logic          bit_q;
  logic [1:0]    pins_nx;

  assign pins_nx = phase_pins(ph_q + 2'd1, bit_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      ph_q     <= '0;
      dwell_q  <= '0;
      bit_q    <= 1'b1;
      cclk_o   <= 1'b1;
      cdata_o  <= 1'b1;
      fin_o    <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (go_i && !active_q) begin
        active_q <= 1'b1;
        ph_q     <= 2'd0;
        dwell_q  <= '0;
        bit_q    <= bit_i;
        {cclk_o, cdata_o} <= phase_pins(2'd0, bit_i);
      end else if (active_q) begin
        if (dwell_q == DWELL_TOP) begin
          dwell_q <= '0;
          if (ph_q == 2'd3) begin
            active_q <= 1'b0;
            fin_o    <= 1'b1;
          end else begin
            ph_q <= ph_q + 2'd1;
            {cclk_o, cdata_o} <= pins_nx;
          end
        end else begin
          dwell_q <= dwell_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
  import cfgl_pkg::*;
#(
  parameter int TICK_DIV    = 50000,
  parameter int WIN_INIT_LO = 4,
  parameter int WIN_INIT_HI = 4,
  parameter int WIN_DONE    = 4,
  parameter int PHASE_CYC   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  logic       bit_valid_i,
  input  logic       bit_data_i,
  input  logic       bit_last_i,
  output logic       bit_ready_o,
  output logic       prog_n_o,
  output logic       cclk_o,
  output logic       cdata_o,
  input  logic       init_i,
  input  logic       done_i,
  output logic       busy_o,
  output logic       finish_o,
  output logic [2:0] result_o
);

  localparam int WIN_MAX1 = (WIN_INIT_LO > WIN_INIT_HI) ? WIN_INIT_LO : WIN_INIT_HI;
  localparam int WIN_MAX  = (WIN_MAX1 > WIN_DONE) ? WIN_MAX1 : WIN_DONE;
  localparam int CW       = $clog2(WIN_MAX + 1);

  cfgl_state_e   state_q;
  logic          last_q;
  logic          init_s, done_s;
  logic          load;
  logic [CW-1:0] limit;
  logic          expired;
  logic          take;
  logic          shift_fin;

  cfgl_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({init_i, done_i}),
    .q_o ({init_s, done_s})
  );

  cfgl_timer #(.TICK_DIV(TICK_DIV), .CW(CW)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .limit_i   (limit),
    .expired_o (expired)
  );

  assign take = (state_q == ST_FETCH) && bit_valid_i && bit_ready_o;

  cfgl_bitphase #(.PHASE_CYC(PHASE_CYC)) u_phase (
    .clk     (clk),
    .rst     (rst),
    .go_i    (take),
    .bit_i   (bit_data_i),
    .cclk_o  (cclk_o),
    .cdata_o (cdata_o),
    .fin_o   (shift_fin)
  );

  // window selection: each wait phase reloads its own limit on entry
  always_comb begin
    load  = 1'b0;
    limit = '0;
    case (state_q)
      ST_IDLE:    if (start_i)              begin load = 1'b1; limit = CW'(WIN_INIT_LO); end
      ST_WAIT_LO: if (!init_s)              begin load = 1'b1; limit = CW'(WIN_INIT_HI); end
      ST_SHIFT:   if (shift_fin && last_q)  begin load = 1'b1; limit = CW'(WIN_DONE);    end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      prog_n_o    <= 1'b1;
      busy_o      <= 1'b0;
      finish_o    <= 1'b0;
      result_o    <= RES_OK;
      bit_ready_o <= 1'b0;
      last_q      <= 1'b0;
    end else begin
      finish_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q  <= ST_WAIT_LO;
            prog_n_o <= 1'b0;
            busy_o   <= 1'b1;
          end
        end
        ST_WAIT_LO: begin
          if (!init_s) begin
            prog_n_o <= 1'b1;
            state_q  <= ST_WAIT_HI;
          end else if (expired) begin
            prog_n_o <= 1'b1;
            state_q  <= ST_IDLE;
            busy_o   <= 1'b0;
            finish_o <= 1'b1;
            result_o <= RES_INIT_LO;
          end
        end
        ST_WAIT_HI: begin
          if (init_s) begin
            state_q     <= ST_FETCH;
            bit_ready_o <= 1'b1;
          end else if (expired) begin
            state_q  <= ST_IDLE;
            busy_o   <= 1'b0;
            finish_o <= 1'b1;
            result_o <= RES_INIT_HI;
          end
        end
        ST_FETCH: begin
          if (take) begin
            bit_ready_o <= 1'b0;
            last_q      <= bit_last_i;
            state_q     <= ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (shift_fin) begin
            if (last_q) begin
              state_q <= ST_WAIT_DONE;
            end else begin
              state_q     <= ST_FETCH;
              bit_ready_o <= 1'b1;
            end
          end
        end
        ST_WAIT_DONE: begin
          if (done_s) begin
            state_q  <= ST_IDLE;
            busy_o   <= 1'b0;
            finish_o <= 1'b1;
            result_o <= RES_OK;
          end else if (expired) begin
            state_q  <= ST_IDLE;
            busy_o   <= 1'b0;
            finish_o <= 1'b1;
            result_o <= RES_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy_o,
  input logic       finish_o,
  input logic [2:0] result_o,
  input logic       prog_n_o,
  input logic       cclk_o,
  input logic       cdata_o,
  input logic       bit_ready_o
);

  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (prog_n_o && cclk_o && cdata_o));

  assert_ready_only_busy_R5: assert property (@(posedge clk) disable iff (rst)
    bit_ready_o |-> busy_o);

  assert_rise_data_stable_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(cclk_o) |-> $stable(cdata_o));

  assert_fall_data_high_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(cclk_o) |-> (cdata_o && $past(cdata_o)));

  assert_prog_high_ready_R7: assert property (@(posedge clk) disable iff (rst)
    bit_ready_o |-> prog_n_o);

  assert_prog_high_clk_low_R7: assert property (@(posedge clk) disable iff (rst)
    !cclk_o |-> prog_n_o);

  assert_legal_code_R8: assert property (@(posedge clk) disable iff (rst)
    (result_o == 3'b000) || (result_o == 3'b111) || (result_o == 3'b110) || (result_o == 3'b101));

  assert_finish_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    finish_o |=> !finish_o);

  assert_busy_fall_with_finish_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> finish_o);

  assert_result_held_R9: assert property (@(posedge clk) disable iff (rst)
    !finish_o |-> $stable(result_o));

endmodule

bind cfg_loader cfg_loader_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy_o      (busy_o),
  .finish_o    (finish_o),
  .result_o    (result_o),
  .prog_n_o    (prog_n_o),
  .cclk_o      (cclk_o),
  .cdata_o     (cdata_o),
  .bit_ready_o (bit_ready_o)
);

// File: tb/sim_cfg_loader.sv
`timescale 1ns/1ps
module sim_cfg_loader;

  localparam int DIV = 4;
  localparam int WLO = 5;
  localparam int WHI = 6;
  localparam int WDN = 8;
  localparam int PH  = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic bit_valid_i = 1'b0, bit_data_i = 1'b0, bit_last_i = 1'b0;
  logic init_i = 1'b1, done_i = 1'b0;
  logic bit_ready_o, prog_n_o, cclk_o, cdata_o, busy_o, finish_o;
  logic [2:0] result_o;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic exp_bits [0:255];
  int rd_idx = 0;
  int low_len = 0;
  logic prev_cclk = 1'b1, prev_cdata = 1'b1;
  logic shifting = 1'b0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cfg_loader #(
    .TICK_DIV(DIV), .WIN_INIT_LO(WLO), .WIN_INIT_HI(WHI), .WIN_DONE(WDN),
    .PHASE_CYC(PH), .SYNC_STAGES(2)
  ) u0 (
    .clk(clk), .rst(rst), .start_i(start_i),
    .bit_valid_i(bit_valid_i), .bit_data_i(bit_data_i), .bit_last_i(bit_last_i),
    .bit_ready_o(bit_ready_o), .prog_n_o(prog_n_o), .cclk_o(cclk_o), .cdata_o(cdata_o),
    .init_i(init_i), .done_i(done_i), .busy_o(busy_o), .finish_o(finish_o),
    .result_o(result_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_code(input int mode);
    case (mode)
      1: exp_code = 3'b111;
      2: exp_code = 3'b110;
      3: exp_code = 3'b101;
      default: exp_code = 3'b000;
    endcase
  endfunction

  // pin observer: checks the four-phase shape and the bit order
  always @(negedge clk) begin
    if (!rst && shifting) begin
      if (!prev_cclk && cclk_o) begin
        chk(cdata_o == exp_bits[rd_idx] && prev_cdata == exp_bits[rd_idx], "R6",
            "data around rising clock", cdata_o, exp_bits[rd_idx]);
        chk(low_len == 2*PH, "R6", "clock low cycles per bit", low_len, 2*PH);
        chk(prog_n_o, "R7", "program high while shifting", prog_n_o, 1);
        rd_idx++;
      end
      if (prev_cclk && !cclk_o)
        chk(cdata_o && prev_cdata, "R6", "data high around falling clock",
            {prev_cdata, cdata_o}, 3);
    end
    if (!cclk_o) low_len++; else low_len = 0;
    prev_cclk  = cclk_o;
    prev_cdata = cdata_o;
  end

  task automatic run(input int nbits, input int mode, input int d_lo, input int d_hi,
                     input int d_dn, input int gapmax);
    int t0;
    int guard;
    done_i  = 1'b0;
    init_i  = 1'b1;
    rd_idx  = 0;
    for (int i = 0; i < nbits; i++) exp_bits[i] = 1'($urandom_range(0, 1));
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    t0 = cyc;
    chk(!prog_n_o && cclk_o && cdata_o && busy_o, "R2", "pins after start",
        {prog_n_o, cclk_o, cdata_o, busy_o}, 4'b0111);
    shifting = 1'b1;
    fork
      begin : target
        if (mode != 1) begin
          repeat (d_lo) @(negedge clk);
          init_i = 1'b0;
          while (!prog_n_o) @(negedge clk);
          chk(busy_o && !bit_ready_o, "R3", "program released after init low", busy_o, 1);
          if (mode != 2) begin
            repeat (d_hi) @(negedge clk);
            init_i = 1'b1;
            while (rd_idx < nbits) @(negedge clk);
            if (mode != 3) begin
              repeat (d_dn) @(negedge clk);
              done_i = 1'b1;
            end
          end
        end
      end
      begin : feeder
        if (mode == 0 || mode == 3) begin
          for (int i = 0; i < nbits; i++) begin
            repeat ($urandom_range(0, gapmax)) @(negedge clk);
            bit_valid_i = 1'b1;
            bit_data_i  = exp_bits[i];
            bit_last_i  = (i == nbits - 1);
            while (!bit_ready_o) @(negedge clk);
            @(negedge clk);
            bit_valid_i = 1'b0;
            bit_last_i  = 1'b0;
          end
        end
      end
    join
    guard = 0;
    while (!finish_o && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    chk(finish_o == 1'b1, "R9", "finish pulse seen", finish_o, 1);
    chk(result_o == exp_code(mode),
        (mode == 1) ? "R3" : (mode == 2) ? "R4" : "R8", "result code",
        result_o, exp_code(mode));
    chk(!busy_o, "R9", "busy low with finish", busy_o, 0);
    if (mode == 1)
      chk((cyc - t0) >= WLO*DIV && (cyc - t0) <= WLO*DIV + 3, "R3", "init-low timeout span",
          cyc - t0, WLO*DIV + 1);
    if (mode == 0 || mode == 3)
      chk(rd_idx == nbits, "R5", "bits shifted out", rd_idx, nbits);
    shifting = 1'b0;
    @(negedge clk);
    chk(!finish_o, "R9", "finish lasts one cycle", finish_o, 0);
    repeat (4) @(negedge clk);
    chk(result_o == exp_code(mode), "R9", "result held", result_o, exp_code(mode));
    chk(prog_n_o && cclk_o && cdata_o && !bit_ready_o, "R1", "idle pins after run",
        {prog_n_o, cclk_o, cdata_o, bit_ready_o}, 4'b1110);
    init_i = 1'b1;
    done_i = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(prog_n_o && cclk_o && cdata_o, "R1", "reset pins high", {prog_n_o, cclk_o, cdata_o}, 7);
    chk(!busy_o && !finish_o && !bit_ready_o && result_o == 3'b000, "R1", "reset status",
        {busy_o, finish_o, bit_ready_o, result_o}, 0);
    // directed: each failing phase, then a late-but-valid response in every phase
    run(0, 1, 0, 0, 0, 0);
    run(0, 2, 3, 0, 0, 0);
    run(5, 3, 2, 2, 0, 2);
    run(6, 0, WLO*DIV - 6, WHI*DIV - 6, WDN*DIV - 6, 1);   // R10
    run(1, 0, 0, 0, 0, 0);
    // random runs
    for (int s = 0; s < 14; s++) begin
      int m;
      m = ($urandom_range(0, 5) == 0) ? int'($urandom_range(1, 3)) : 0;
      run($urandom_range(1, 40), m, $urandom_range(0, WLO*DIV - 6),
          $urandom_range(0, WHI*DIV - 6), $urandom_range(0, WDN*DIV - 8),
          $urandom_range(0, 4));
    end
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule